// File: doc/BRIEF.md
# Receive Frame Address Filter

This block decides whether an incoming Ethernet frame should be kept, based only on its header. It takes the 48-bit destination address and the 16-bit type/length field on a header strobe. It compares them against a set of programmable criteria and reports, one clock later, an accept flag and a code that names the criterion that fired.

Five criteria are ORed to reach the decision:

- four specific-address slots;
- four type-ID slots;
- a 64-bit hash table indexed by a fold of the destination address;
- an all-ones broadcast check, gated by an allow bit;
- a copy-all mode that takes every frame.

When more than one criterion matches, the reason code reports only the highest-priority one. Storing the frame, checking its CRC and moving it to memory are done elsewhere.

Top module: `rx_addr_filter`

## Requirements
- R1: When `dst_addr` equals enabled address slot i (bits `[48*i +: 48]` of `cfg_addr`, enable `cfg_addr_en[i]`), the frame is accepted with reason code 1+i (slot 0 gives 1, slot 3 gives 4).
- R2: When `len_type` equals enabled type slot j (bits `[16*j +: 16]` of `cfg_type`, enable `cfg_type_en[j]`), the frame is accepted with reason code 5+j (slot 0 gives 5, slot 3 gives 8).
- R3: A slot whose enable bit is 0 never causes acceptance. Setting its enable makes the same header match it.
- R4: The hash index is 6 bits. Index bit k is the XOR of `dst_addr` bits k, k+6, k+12, ... up to bit 47. When `cfg_hash` bit [index] is 1, the frame is accepted with reason code 9.
- R5: A destination of all ones is accepted with reason code 10 only while `cfg_bcast_en` is 1.
- R6: With `cfg_copy_all` at 1 every frame is accepted. When no other criterion hits, the reason code is 11.
- R7: When several criteria hit, the reason code is that of the highest-priority hit. The order, highest first, is: address slot 0 to 3, type slot 0 to 3, hash, broadcast, copy-all.
- R8: `res_valid` is 1 exactly in the cycle after a cycle with `hdr_valid` at 1. In a cycle after one without the strobe, `res_valid`, `res_accept` and `res_reason` are all 0.
- R9: While `rst_n` is low, and right after it rises, `res_valid`, `res_accept` and `res_reason` are 0.
- R10: A strobed header that meets no criterion gives `res_valid`=1, `res_accept`=0 and `res_reason`=0. `res_accept` is 1 exactly when `res_reason` is not 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Header strobe, one cycle per frame |
| dst_addr | input | 48 | Destination address |
| len_type | input | 16 | Type/length field |
| cfg_addr | input | 192 | Four specific addresses, slot i in bits [48*i +: 48] |
| cfg_addr_en | input | 4 | Per-slot enable for address slots |
| cfg_type | input | 64 | Four type IDs, slot j in bits [16*j +: 16] |
| cfg_type_en | input | 4 | Per-slot enable for type slots |
| cfg_hash | input | 64 | Hash table, one bit per index |
| cfg_bcast_en | input | 1 | Allow broadcast frames |
| cfg_copy_all | input | 1 | Accept every frame |
| res_valid | output | 1 | Result valid, one cycle after the strobe |
| res_accept | output | 1 | Frame accepted |
| res_reason | output | 4 | Code of the highest-priority criterion that hit |

## Verification
The only state is the single result register. A wrong internal state can only show up as a wrong accept flag, a wrong reason code or a wrong valid on the next cycle after the strobe. Every fault is therefore visible at the ports within one clock.

The vector table drives headers that isolate each slot, each hash index class, broadcast and overlapping hits. This exposes a wrong slot index, a wrong enable gate, a mis-folded hash bit or an inverted priority through the reported code.

Directed cases cover reset, a missing strobe, broadcast disallowed, copy-all, and a slot enabled after first being disabled.

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter int N_ADDR = 4,
  parameter int N_TYPE = 4,
  parameter int AW     = 48,
  parameter int TW     = 16,
  parameter int HB     = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   hdr_valid,
  input  logic [AW-1:0]          dst_addr,
  input  logic [TW-1:0]          len_type,
  input  logic [N_ADDR*AW-1:0]   cfg_addr,
  input  logic [N_ADDR-1:0]      cfg_addr_en,
  input  logic [N_TYPE*TW-1:0]   cfg_type,
  input  logic [N_TYPE-1:0]      cfg_type_en,
  input  logic [(1<<HB)-1:0]     cfg_hash,
  input  logic                   cfg_bcast_en,
  input  logic                   cfg_copy_all,
  output logic                   res_valid,
  output logic                   res_accept,
  output logic [$clog2(N_ADDR+N_TYPE+4)-1:0] res_reason
);
  localparam int RW      = $clog2(N_ADDR + N_TYPE + 4);
  localparam int C_TYPE0 = 1 + N_ADDR;
  localparam int C_HASH  = 1 + N_ADDR + N_TYPE;
  localparam int C_BCAST = C_HASH + 1;
  localparam int C_COPY  = C_HASH + 2;

  logic [N_ADDR-1:0] addr_hit;
  logic [N_TYPE-1:0] type_hit;
  logic [HB-1:0]     hidx;
  logic              hash_hit, bcast_hit;
  logic [RW-1:0]     code;

  for (genvar i = 0; i < N_ADDR; i++) begin : g_addr
    assign addr_hit[i] = cfg_addr_en[i] && (dst_addr == cfg_addr[i*AW +: AW]);
  end

  for (genvar j = 0; j < N_TYPE; j++) begin : g_type
    assign type_hit[j] = cfg_type_en[j] && (len_type == cfg_type[j*TW +: TW]);
  end

  always_comb begin
    for (int k = 0; k < HB; k++) begin
      hidx[k] = 1'b0;
      for (int b = k; b < AW; b += HB) hidx[k] = hidx[k] ^ dst_addr[b];
    end
  end

  assign hash_hit  = cfg_hash[hidx];
  assign bcast_hit = cfg_bcast_en && (&dst_addr);

  always_comb begin
    code = '0;
    if (cfg_copy_all) code = RW'(C_COPY);
    if (bcast_hit)    code = RW'(C_BCAST);
    if (hash_hit)     code = RW'(C_HASH);
    for (int j = N_TYPE - 1; j >= 0; j--)
      if (type_hit[j]) code = RW'(C_TYPE0 + j);
    for (int i = N_ADDR - 1; i >= 0; i--)
      if (addr_hit[i]) code = RW'(1 + i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_reason <= '0;
    end else begin
      res_valid  <= hdr_valid;
      res_accept <= hdr_valid && (code != '0);
      res_reason <= hdr_valid ? code : '0;
    end
  end

  p_copy_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && cfg_copy_all |=> res_accept);

  p_bcast_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && cfg_bcast_en && (&dst_addr) |=> res_accept);

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_valid |=> !res_valid && !res_accept && (res_reason == '0));

  p_slot0_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && cfg_addr_en[0] && (dst_addr == cfg_addr[AW-1:0]) |=> res_reason == RW'(1));

  p_accept_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_accept == (res_reason != '0));

  p_reset_r9: assert property (@(posedge clk)
    !rst_n |=> !res_valid && !res_accept);
endmodule

// File: tb/test_rx_addr_filter.sv
module test_rx_addr_filter;
  logic clk = 0, rst_n = 0, hdr_valid = 0;
  logic [47:0]  dst_addr = '0;
  logic [15:0]  len_type = '0;
  logic [191:0] cfg_addr;
  logic [3:0]   cfg_addr_en;
  logic [63:0]  cfg_type;
  logic [3:0]   cfg_type_en;
  logic [63:0]  cfg_hash;
  logic         cfg_bcast_en, cfg_copy_all;
  logic         res_valid, res_accept;
  logic [3:0]   res_reason;
  int vectors = 0, errors = 0;

  always #4 clk = ~clk;

  rx_addr_filter i_rx_addr_filter (.*);

  localparam logic [47:0] NEU = 48'h0A0000000000;
  localparam logic [68:0] VEC [0:15] = '{
    {48'h020000000001, 16'h1234, 1'b1, 4'd1},
    {48'h020000000002, 16'h1234, 1'b1, 4'd2},
    {48'h020000000003, 16'h1234, 1'b0, 4'd0},
    {48'h020000000004, 16'h1234, 1'b1, 4'd4},
    {NEU,              16'h0800, 1'b1, 4'd5},
    {NEU,              16'h86DD, 1'b1, 4'd6},
    {NEU,              16'h88CC, 1'b0, 4'd0},
    {NEU,              16'h8100, 1'b1, 4'd8},
    {48'h000000000005, 16'h1234, 1'b1, 4'd9},
    {48'h800000000000, 16'h1234, 1'b1, 4'd9},
    {48'h000000000041, 16'h1234, 1'b0, 4'd0},
    {48'hFFFFFFFFFFFF, 16'h1234, 1'b1, 4'd10},
    {48'h020000000004, 16'h0800, 1'b1, 4'd4},
    {48'hFFFFFFFFFFFF, 16'h8100, 1'b1, 4'd8},
    {48'h020000000001, 16'h0800, 1'b1, 4'd1},
    {48'h000000000005, 16'h86DD, 1'b1, 4'd6}
  };

  task automatic check(input string req, input logic v, input logic a, input logic [3:0] r);
    vectors++;
    if (res_valid !== v || res_accept !== a || res_reason !== r) begin
      errors++;
      $display("FAIL %s: got valid=%0b accept=%0b reason=%0d, expected valid=%0b accept=%0b reason=%0d",
               req, res_valid, res_accept, res_reason, v, a, r);
    end
  endtask

  task automatic apply(input logic [47:0] d, input logic [15:0] t, input string req,
                       input logic a, input logic [3:0] r);
    @(negedge clk);
    dst_addr = d; len_type = t; hdr_valid = 1;
    @(negedge clk);
    hdr_valid = 0;
    check(req, 1'b1, a, r);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: got hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    cfg_addr     = {48'h020000000004, 48'h020000000003, 48'h020000000002, 48'h020000000001};
    cfg_addr_en  = 4'b1011;
    cfg_type     = {16'h8100, 16'h88CC, 16'h86DD, 16'h0800};
    cfg_type_en  = 4'b1011;
    cfg_hash     = (64'd1 << 5) | (64'd1 << 32);
    cfg_bcast_en = 1; cfg_copy_all = 0;
    hdr_valid = 1;
    repeat (3) @(negedge clk);
    check("R9 reset", 1'b0, 1'b0, 4'd0);
    hdr_valid = 0;
    rst_n = 1;
    @(negedge clk);
    check("R9 after reset", 1'b0, 1'b0, 4'd0);

    // R1 R2 R3 R4 R5 R7 R10 table
    for (int n = 0; n < 16; n++)
      apply(VEC[n][68:21], VEC[n][20:5], "R1/R2/R3/R4/R5/R7/R10 table", VEC[n][4], VEC[n][3:0]);

    // R8: no strobe gives idle result
    @(negedge clk);
    check("R8 idle", 1'b0, 1'b0, 4'd0);

    // R5: broadcast disallowed
    cfg_bcast_en = 0;
    apply(48'hFFFFFFFFFFFF, 16'h1234, "R5 bcast off", 1'b0, 4'd0);
    cfg_bcast_en = 1;

    // R6: copy-all alone, and under an address hit (R7)
    cfg_copy_all = 1;
    apply(NEU, 16'h1234, "R6 copy-all", 1'b1, 4'd11);
    apply(48'h020000000002, 16'h1234, "R7 addr over copy-all", 1'b1, 4'd2);
    apply(48'hFFFFFFFFFFFF, 16'h1234, "R7 bcast over copy-all", 1'b1, 4'd10);
    cfg_copy_all = 0;

    // R3: enabling a slot makes it match
    cfg_addr_en[2] = 1;
    apply(48'h020000000003, 16'h1234, "R3 slot2 enabled", 1'b1, 4'd3);
    cfg_type_en[2] = 1;
    apply(NEU, 16'h88CC, "R3 type slot2 enabled", 1'b1, 4'd7);

    // R4: hash bit cleared stops the hit
    cfg_hash[5] = 0;
    apply(48'h000000000005, 16'h1234, "R4 hash bit cleared", 1'b0, 4'd0);

    // R8: result lasts one cycle only
    @(negedge clk);
    check("R8 single cycle", 1'b0, 1'b0, 4'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule